// File: doc/BRIEF.md
# Flash Reprogramming Control Register Unit

This unit holds the memory-mapped control and status register that software uses to put an on-chip flash sequencer into reprogramming mode, reset the flash control logic, and choose which ROM area is visible while the device runs its boot program. It also decides, one write at a time, whether a bus write aimed at the flash space is a valid software command. Accepted commands go to the sequencer over a one-cycle valid strobe with address and a full 16-bit data word.

Reprogramming mode is guarded by a two-step unlock: software writes 0 and then, as the very next bus write, 1 to the mode bit. Commands are accepted only in that mode, only at even byte addresses, and only while the flash control reset is released. A small counter-based sequencer stub is included. It reports busy for a set number of cycles per command, and it raises an abort strobe when a reset cuts an operation short. Its busy state is shown to software through the register's read-only ready bit.

Top module: `fcr_unit`

## Requirements
- R1: Register bit 0 (ready) is read-only. It reads 0 while the sequencer is busy and 1 otherwise. Busy rises on the second clock edge after an accepted command write and lasts BUSY_CYC cycles. `seq_busy` mirrors it.
- R2: Bit 1 (mode) is set only when a register write with bit 1 = 1 immediately follows a register write with bit 1 = 0. Any bus write in between, including a flash-space write, breaks the sequence.
- R3: A register write with bit 1 = 0 clears the mode bit in the cycle after the write.
- R4: A write to any address other than CTRL_ADDR with address bit 0 = 0, made while mode = 1 and bit 3 = 0, produces a one-cycle `cmd_valid` with that address and all 16 data bits in the cycle after the write. With mode = 0 the write is dropped.
- R5: A flash-space write with address bit 0 = 1 is dropped, with no `cmd_valid`.
- R6: Bit 3 (flash reset) becomes 1 on a write of 1 only if mode was already 1. A write of 0 clears it. It drives `flash_rst`, and no command is accepted while it is 1.
- R7: If the flash reset bit, `wdt_irq` or `sw_rst` is high while the sequencer is busy, busy drops on the next edge and `seq_abort` pulses for exactly one cycle.
- R8: `rst_n` low, or `wdt_irq` or `sw_rst` sampled high, clears bits 1, 3 and 5. The register then reads 0x01.
- R9: Bit 5 (user area) is written only while `boot_mode` = 1, and it reads and drives `user_area` only while `boot_mode` = 1. Otherwise it reads 0 and register writes leave it unchanged.
- R10: Bits 2, 4, 6 and 7 always read 0, whatever value is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| wdt_irq | input | 1 | Watchdog interrupt request; clears the register and the sequencer |
| sw_rst | input | 1 | Software reset; clears the register and the sequencer |
| boot_mode | input | 1 | Device is running from its boot area |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Byte address of the write |
| bus_wdata | input | 16 | Write data |
| ctrl_rdata | output | 8 | Current register value |
| cmd_valid | output | 1 | Accepted command strobe |
| cmd_addr | output | ADDR_W | Address of the accepted command |
| cmd_data | output | 16 | Data of the accepted command |
| flash_rst | output | 1 | Flash control reset request |
| user_area | output | 1 | User ROM area selected (boot mode only) |
| seq_busy | output | 1 | Sequencer busy |
| seq_abort | output | 1 | One-cycle abort strobe |

## Verification
Register bits 1, 3 and 5 change on the clock edge that samples the write, so the bench reads `ctrl_rdata` at the falling edge right after that edge. `cmd_valid` is registered and is checked at the same falling edge, and again one cycle later to confirm it lasts a single cycle. Busy is one register further on. The bench reads ready as 0 one cycle after the command strobe and then counts falling edges until ready returns, expecting exactly BUSY_CYC. The abort strobe comes one edge after the reset bit is taken, so the bench first checks that it is still low and then checks it one cycle later.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int REG_W    = 8;
  localparam int DATA_W   = 16;
  localparam int BIT_RDY  = 0;
  localparam int BIT_MODE = 1;
  localparam int BIT_FRST = 3;
  localparam int BIT_AREA = 5;
endpackage

// File: rtl/fcr_rst_sync.sv
module fcr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/fcr_ctrl_reg.sv
module fcr_ctrl_reg (
  input  logic clk,
  input  logic rst_ns,
  input  logic sys_clr,
  input  logic boot_mode,
  input  logic reg_wr,
  input  logic any_wr,
  input  logic wr_mode,
  input  logic wr_frst,
  input  logic wr_area,
  output logic mode_q,
  output logic frst_q,
  output logic area_q
);
  logic armed_q, armed_d, mode_d, frst_d, area_d;

  always_comb begin
    armed_d = armed_q;
    mode_d  = mode_q;
    frst_d  = frst_q;
    area_d  = area_q;
    if (sys_clr) begin
      armed_d = 1'b0;
      mode_d  = 1'b0;
      frst_d  = 1'b0;
      area_d  = 1'b0;
    end else if (reg_wr) begin
      armed_d = ~wr_mode;
      if (!wr_mode)     mode_d = 1'b0;
      else if (armed_q) mode_d = 1'b1;
      frst_d = wr_frst ? (frst_q | mode_q) : 1'b0;
      if (boot_mode) area_d = wr_area;
    end else if (any_wr) begin
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      armed_q <= 1'b0;
      mode_q  <= 1'b0;
      frst_q  <= 1'b0;
      area_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      mode_q  <= mode_d;
      frst_q  <= frst_d;
      area_q  <= area_d;
    end
  end

  AST_MODE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(mode_q) |-> $past(armed_q) && $past(reg_wr)); // R2
  AST_FRST_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(frst_q) |-> $past(mode_q)); // R6
  AST_AREA_BOOT_ONLY: assert property (@(posedge clk) disable iff (!rst_ns)
    (!boot_mode && !sys_clr) |=> $stable(area_q)); // R9
endmodule

// File: rtl/fcr_cmd_gate.sv
module fcr_cmd_gate #(
  parameter int ADDR_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_ns,
  input  logic                      sys_clr,
  input  logic                      flash_wr,
  input  logic                      mode_q,
  input  logic                      frst_q,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [fcr_pkg::DATA_W-1:0] data,
  output logic                      cmd_valid,
  output logic [ADDR_W-1:0]         cmd_addr,
  output logic [fcr_pkg::DATA_W-1:0] cmd_data
);
  logic accept, valid_d;

  always_comb begin
    accept  = flash_wr && mode_q && !frst_q && !addr[0] && !sys_clr;
    valid_d = accept;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) cmd_valid <= 1'b0;
    else         cmd_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cmd_addr <= '0;
      cmd_data <= '0;
    end else if (accept) begin
      cmd_addr <= addr;
      cmd_data <= data;
    end
  end

  AST_CMD_EVEN_MODE: assert property (@(posedge clk) disable iff (!rst_ns)
    cmd_valid |-> $past(mode_q) && !$past(frst_q) && !cmd_addr[0]); // R4
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_ns)
    cmd_valid |=> !cmd_valid || $past(accept)); // R5
endmodule

// File: rtl/fcr_seq_stub.sv
module fcr_seq_stub #(
  parameter int BUSY_CYC = 4
) (
  input  logic clk,
  input  logic rst_ns,
  input  logic clr,
  input  logic start,
  output logic busy,
  output logic abort
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic busy_d, abort_d;

  always_comb begin
    cnt_d   = cnt_q;
    busy_d  = busy;
    abort_d = 1'b0;
    if (clr) begin
      abort_d = busy;
      busy_d  = 1'b0;
      cnt_d   = '0;
    end else if (busy) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(BUSY_CYC - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cnt_q <= '0;
      busy  <= 1'b0;
      abort <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      busy  <= busy_d;
      abort <= abort_d;
    end
  end

  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(busy) |-> $past(start)); // R1
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_ns)
    abort |-> $past(busy) && $past(clr) && !busy); // R7
endmodule

// File: rtl/fcr_unit.sv
module fcr_unit #(
  parameter int          ADDR_W    = 16,
  parameter int          BUSY_CYC  = 4,
  parameter logic [15:0] CTRL_ADDR = 16'h005E
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wdt_irq,
  input  logic                       sw_rst,
  input  logic                       boot_mode,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [fcr_pkg::DATA_W-1:0] bus_wdata,
  output logic [fcr_pkg::REG_W-1:0]  ctrl_rdata,
  output logic                       cmd_valid,
  output logic [ADDR_W-1:0]          cmd_addr,
  output logic [fcr_pkg::DATA_W-1:0] cmd_data,
  output logic                       flash_rst,
  output logic                       user_area,
  output logic                       seq_busy,
  output logic                       seq_abort
);
  import fcr_pkg::*;

  logic rst_ns, sys_clr, reg_wr, flash_wr;
  logic mode_q, frst_q, area_q, busy;

  assign sys_clr  = wdt_irq | sw_rst;
  assign reg_wr   = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
  assign flash_wr = bus_wr && !reg_wr;

  fcr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  fcr_ctrl_reg u_reg (
    .clk(clk), .rst_ns(rst_ns), .sys_clr(sys_clr), .boot_mode(boot_mode),
    .reg_wr(reg_wr), .any_wr(bus_wr),
    .wr_mode(bus_wdata[BIT_MODE]), .wr_frst(bus_wdata[BIT_FRST]),
    .wr_area(bus_wdata[BIT_AREA]),
    .mode_q(mode_q), .frst_q(frst_q), .area_q(area_q)
  );

  fcr_cmd_gate #(.ADDR_W(ADDR_W)) u_gate (
    .clk(clk), .rst_ns(rst_ns), .sys_clr(sys_clr), .flash_wr(flash_wr),
    .mode_q(mode_q), .frst_q(frst_q), .addr(bus_addr), .data(bus_wdata),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  fcr_seq_stub #(.BUSY_CYC(BUSY_CYC)) u_seq (
    .clk(clk), .rst_ns(rst_ns), .clr(frst_q | sys_clr), .start(cmd_valid),
    .busy(busy), .abort(seq_abort)
  );

  always_comb begin
    ctrl_rdata           = '0;
    ctrl_rdata[BIT_RDY]  = ~busy;
    ctrl_rdata[BIT_MODE] = mode_q;
    ctrl_rdata[BIT_FRST] = frst_q;
    ctrl_rdata[BIT_AREA] = area_q & boot_mode;
  end

  assign flash_rst = frst_q;
  assign user_area = area_q & boot_mode;
  assign seq_busy  = busy;

  AST_CLR_EMPTIES_REG: assert property (@(posedge clk) disable iff (!rst_ns)
    sys_clr |=> !mode_q && !frst_q && !area_q); // R8
  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_wr && !bus_wdata[BIT_MODE]) |=> !mode_q); // R3
endmodule

// File: tb/fcr_unit_test.sv
`timescale 1ns/1ps
module fcr_unit_test;
  localparam int          N    = 4;
  localparam logic [15:0] CREG = 16'h005E;

  logic clk = 1'b0;
  logic rst_n, wdt_irq, sw_rst, boot_mode, bus_wr;
  logic [15:0] bus_addr, bus_wdata, cmd_addr, cmd_data;
  logic [7:0]  ctrl_rdata;
  logic cmd_valid, flash_rst, user_area, seq_busy, seq_abort;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fcr_unit #(.ADDR_W(16), .BUSY_CYC(N), .CTRL_ADDR(CREG)) uut (
    .clk(clk), .rst_n(rst_n), .wdt_irq(wdt_irq), .sw_rst(sw_rst),
    .boot_mode(boot_mode), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ctrl_rdata(ctrl_rdata), .cmd_valid(cmd_valid),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .flash_rst(flash_rst),
    .user_area(user_area), .seq_busy(seq_busy), .seq_abort(seq_abort));

  // {write data, expected register after}; boot_mode = 1, sequencer idle
  localparam logic [23:0] VEC [0:8] = '{
    {16'h0002, 8'h01},  // R2 one without a preceding zero
    {16'h0000, 8'h01},  // R2 arm
    {16'h0002, 8'h03},  // R2 unlock
    {16'h000A, 8'h0B},  // R6 reset bit with mode on
    {16'h0002, 8'h03},  // R6 reset bit cleared
    {16'h0022, 8'h23},  // R9 area in boot mode
    {16'h0000, 8'h01},  // R3 mode cleared by zero
    {16'h0008, 8'h01},  // R6 reset bit ignored with mode off
    {16'h00D2, 8'h03}   // R10 unused bits stay zero, R2 re-armed
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int cnt;
    rst_n = 1'b0; wdt_irq = 1'b0; sw_rst = 1'b0; boot_mode = 1'b1;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 reset value", ctrl_rdata, 8'h01);
    chk("R1 idle busy", seq_busy, 0);

    for (int i = 0; i < 9; i++) begin
      wr(CREG, VEC[i][23:8]);
      chk($sformatf("R2/R3/R6/R9/R10 vector %0d", i), ctrl_rdata, VEC[i][7:0]);
    end

    // mode is 1 here; even command
    wr(16'h1000, 16'hA55A);
    chk("R4 cmd_valid", cmd_valid, 1);
    chk("R4 cmd_addr", cmd_addr, 16'h1000);
    chk("R4 cmd_data", cmd_data, 16'hA55A);
    @(negedge clk);
    chk("R4 single strobe", cmd_valid, 0);
    chk("R1 ready low", ctrl_rdata[0], 0);
    cnt = 0;
    while (ctrl_rdata[0] == 1'b0 && cnt < 20) begin
      cnt++;
      @(negedge clk);
    end
    chk("R1 busy length", cnt, N);

    // odd address dropped
    wr(16'h1001, 16'h1234);
    chk("R5 odd dropped", cmd_valid, 0);
    @(negedge clk);
    chk("R5 no busy", seq_busy, 0);

    // abort by flash reset bit
    wr(16'h2000, 16'h00FF);
    @(negedge clk);
    chk("R7 busy before abort", seq_busy, 1);
    wr(CREG, 16'h000A);
    chk("R6 flash_rst out", flash_rst, 1);
    chk("R7 abort not yet", seq_abort, 0);
    @(negedge clk);
    chk("R7 abort pulse", seq_abort, 1);
    chk("R7 busy cleared", seq_busy, 0);
    @(negedge clk);
    chk("R7 abort one cycle", seq_abort, 0);
    wr(16'h2002, 16'h0001);
    chk("R6 cmd blocked by reset bit", cmd_valid, 0);
    wr(CREG, 16'h0002);
    chk("R6 reset bit cleared", ctrl_rdata, 8'h03);

    // unlock broken by an intervening write
    wr(CREG, 16'h0000);
    wr(16'h3000, 16'h0000);
    chk("R4 cmd ignored with mode off", cmd_valid, 0);
    wr(CREG, 16'h0002);
    chk("R2 broken sequence", ctrl_rdata, 8'h01);

    // boot mode area select
    wr(CREG, 16'h0020);
    chk("R9 area set", user_area, 1);
    boot_mode = 1'b0;
    #1;
    chk("R9 area masked", ctrl_rdata, 8'h01);
    wr(CREG, 16'h0000);
    boot_mode = 1'b1;
    #1;
    chk("R9 write ignored outside boot", ctrl_rdata, 8'h21);

    // watchdog clear with sequencer busy
    wr(CREG, 16'h0000);
    wr(CREG, 16'h0022);
    wr(16'h4000, 16'h0BEE);
    @(negedge clk);
    wdt_irq = 1'b1;
    @(negedge clk);
    wdt_irq = 1'b0;
    chk("R8 watchdog clears", ctrl_rdata, 8'h01);
    chk("R7 watchdog abort", seq_abort, 1);

    // software reset
    wr(CREG, 16'h0000);
    wr(CREG, 16'h0002);
    sw_rst = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
    chk("R8 software reset", ctrl_rdata, 8'h01);

    // external reset
    wr(CREG, 16'h0000);
    wr(CREG, 16'h0022);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 external reset", ctrl_rdata, 8'h01);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule